// File: doc/BRIEF.md
# SPI Slave Register Port

This block lets an external SPI master read and write a small bank of 8-bit control registers and read a bank of status registers. The block runs on a system clock and oversamples the three SPI input pins (serial clock, active-low chip select, serial data in). It drives the serial data out pin. Every transaction is a command byte followed by a data byte. The command byte carries a write flag in bit 7 and a register address in bits 4:0.

Read data is pipelined. When the eighth bit of a command byte ends, the value of the addressed register is loaded into the output shift register. That value then leaves on the data-out pin during the next eight serial clocks. The bits the master sends during that byte are decoded as the next command, so reads can run back to back while chip select stays low.

A write is held back until chip select returns high. It takes effect only if exactly sixteen serial clocks arrived in that select window; with any other count the whole packet is dropped. Status registers sit in the upper half of the address space. A one-cycle read strobe and the address go out toward the status bank, which returns the byte in the same cycle.

Top module: `spi_reg_port`

## Requirements
- R1: While reset is held and after reset, `spi_sdo` is 0, every control register is 0x00 and `status_rd_o` is low. Until the first command byte is decoded, `spi_sdo` keeps sending 0x00.
- R2: The SPI mode is mode 0. `spi_sdi` is sampled on rising `spi_sck`, `spi_sdo` changes on falling `spi_sck`, and bytes go MSB first. In the byte after a read command, `spi_sdo` carries the addressed register's value. `spi_sdo` does not change while `spi_cs_n` is high.
- R3: A read command to an address with bit 4 set raises `status_rd_o` for exactly one system clock, with `status_addr_o` equal to that address. The byte then returned on `spi_sdo` is `status_data_i` as seen in that cycle.
- R4: With `spi_cs_n` held low, each byte received after a read command is decoded as a new command. The response to it comes out in the byte after it.
- R5: A write command (bit 7 = 1) to control address A (A below NUM_CTRL), followed by data byte D, sets register A to D only once `spi_cs_n` has gone high. Before that the register is unchanged.
- R6: A write packet is discarded if the select window did not hold exactly 16 serial clocks, for example 15 or 24.
- R7: A write to a status address or to an unmapped address changes no control register and does not pulse `status_rd_o`.
- R8: During each byte, `spi_sdo` sends the value that the most recently received address held when the previous byte ended. For the data byte of a write, that is the register's old content.
- R9: Bits 6:5 of the command byte are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sck | input | 1 | Serial clock from master (asynchronous) |
| spi_cs_n | input | 1 | Active-low chip select (asynchronous) |
| spi_sdi | input | 1 | Serial data from master |
| spi_sdo | output | 1 | Serial data to master |
| status_rd_o | output | 1 | One-cycle strobe when a status register is read |
| status_addr_o | output | ADDR_W | Address of the register being read |
| status_data_i | input | 8 | Status byte for `status_addr_o`, returned in the same cycle |
| ctrl_regs_o | output | NUM_CTRL*8 | Control registers, register i at bits [8i+7:8i] |

## Verification
Each pin passes through two synchronizer flops and an edge flop. A new `spi_sdo` bit therefore settles about four system clocks after a falling serial clock. The bench holds each serial clock phase for eight system clocks and samples `spi_sdo` just before raising the serial clock. A write commits about four clocks after chip select rises. The bench checks the register once just before that rise, when it must still hold its old value, and again twelve clocks after the rise, when it must hold the new value. The status strobe appears in the load cycle a few clocks after the eighth falling edge, so a monitor counts strobes on every system clock. The strobe count and its address are compared after each frame.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned FRAME_BITS  = 2 * BYTE_W;
  localparam int unsigned WR_FLAG_BIT = BYTE_W - 1;

  // Meaning of the next complete byte inside a select window
  typedef enum logic {
    ROLE_CMD  = 1'b0,
    ROLE_DATA = 1'b1
  } byte_role_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned   N       = 3,
  parameter int unsigned   STAGES  = 2,
  parameter logic [N-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);

  // stage 0..STAGES-1 synchronise, stage STAGES holds the previous value
  logic [STAGES:0][N-1:0] stage_q;
  logic [STAGES:0][N-1:0] stage_n;

  always_comb begin
    stage_n = {stage_q[STAGES-1:0], pins_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {(STAGES+1){RST_VAL}};
    end else begin
      stage_q <= stage_n;
    end
  end

  assign sync_o = stage_q[STAGES-1];
  assign rise_o = stage_q[STAGES-1] & ~stage_q[STAGES];
  assign fall_o = ~stage_q[STAGES-1] & stage_q[STAGES];

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_reg_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active_i,
  input  logic              cs_start_i,
  input  logic              cs_end_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              sdi_i,
  output logic              load_o,
  output logic              shift_o,
  output logic              load_cmd_o,
  output logic              cmd_wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              commit_o,
  output logic [BYTE_W-1:0] wr_data_o
);

  localparam int unsigned CNT_W     = $clog2(FRAME_BITS + 2);
  localparam int unsigned BIT_IDX_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0]     CNT_MAX    = '1;
  localparam logic [CNT_W-1:0]     CNT_FULL   = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0]     CNT_LASTWR = CNT_W'(FRAME_BITS - 1);
  localparam logic [BIT_IDX_W-1:0] LAST_IDX   = BIT_IDX_W'(BYTE_W - 1);

  logic [BYTE_W-2:0]    rx_q,        rx_n;
  logic [BIT_IDX_W-1:0] bit_idx_q,   bit_idx_n;
  logic [CNT_W-1:0]     cnt_q,       cnt_n;
  byte_role_e           role_q,      role_n;
  logic                 byte_done_q, byte_done_n;
  logic                 done_cmd_q,  done_cmd_n;
  logic                 cmd_wr_q,    cmd_wr_n;
  logic [ADDR_W-1:0]    addr_q,      addr_n;
  logic                 wr_pend_q,   wr_pend_n;
  logic [BYTE_W-1:0]    wr_data_q,   wr_data_n;
  logic [BYTE_W-1:0]    full_byte;

  assign full_byte = {rx_q, sdi_i};

  always_comb begin
    rx_n        = rx_q;
    bit_idx_n   = bit_idx_q;
    cnt_n       = cnt_q;
    role_n      = role_q;
    byte_done_n = byte_done_q;
    done_cmd_n  = done_cmd_q;
    cmd_wr_n    = cmd_wr_q;
    addr_n      = addr_q;
    wr_pend_n   = wr_pend_q;
    wr_data_n   = wr_data_q;

    if (cs_start_i) begin
      bit_idx_n   = '0;
      cnt_n       = '0;
      role_n      = ROLE_CMD;
      byte_done_n = 1'b0;
      wr_pend_n   = 1'b0;
    end else if (cs_end_i) begin
      wr_pend_n   = 1'b0;
    end else if (cs_active_i) begin
      if (sck_rise_i) begin
        rx_n      = full_byte[BYTE_W-2:0];
        bit_idx_n = bit_idx_q + 1'b1;
        if (cnt_q != CNT_MAX) begin
          cnt_n = cnt_q + 1'b1;
        end
        if (bit_idx_q == LAST_IDX) begin
          byte_done_n = 1'b1;
          done_cmd_n  = (role_q == ROLE_CMD);
          if (role_q == ROLE_CMD) begin
            addr_n   = full_byte[ADDR_W-1:0];
            cmd_wr_n = full_byte[WR_FLAG_BIT];
            role_n   = full_byte[WR_FLAG_BIT] ? ROLE_DATA : ROLE_CMD;
          end else begin
            role_n = ROLE_CMD;
            if (cmd_wr_q && (cnt_q == CNT_LASTWR)) begin
              wr_pend_n = 1'b1;
              wr_data_n = full_byte;
            end
          end
        end
      end
      if (sck_fall_i && byte_done_q) begin
        byte_done_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q        <= '0;
      bit_idx_q   <= '0;
      cnt_q       <= '0;
      role_q      <= ROLE_CMD;
      byte_done_q <= 1'b0;
      done_cmd_q  <= 1'b0;
      cmd_wr_q    <= 1'b0;
      addr_q      <= '0;
      wr_pend_q   <= 1'b0;
      wr_data_q   <= '0;
    end else begin
      rx_q        <= rx_n;
      bit_idx_q   <= bit_idx_n;
      cnt_q       <= cnt_n;
      role_q      <= role_n;
      byte_done_q <= byte_done_n;
      done_cmd_q  <= done_cmd_n;
      cmd_wr_q    <= cmd_wr_n;
      addr_q      <= addr_n;
      wr_pend_q   <= wr_pend_n;
      wr_data_q   <= wr_data_n;
    end
  end

  assign load_o     = cs_active_i & sck_fall_i & byte_done_q;
  assign shift_o    = cs_active_i & sck_fall_i & ~byte_done_q;
  assign load_cmd_o = done_cmd_q;
  assign cmd_wr_o   = cmd_wr_q;
  assign addr_o     = addr_q;
  assign commit_o   = cs_end_i & wr_pend_q & (cnt_q == CNT_FULL);
  assign wr_data_o  = wr_data_q;

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
  import spi_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              sdo_o
);

  logic [BYTE_W-1:0] tx_q, tx_n;

  always_comb begin
    tx_n = tx_q;
    if (load_i) begin
      tx_n = data_i;
    end else if (shift_i) begin
      tx_n = {tx_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else begin
      tx_q <= tx_n;
    end
  end

  assign sdo_o = tx_q[BYTE_W-1];

endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
  import spi_reg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [BYTE_W-1:0]          wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [BYTE_W-1:0]          rd_data_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic              sel;
    logic [BYTE_W-1:0] val_q;

    assign sel = wr_en_i && (wr_addr_i == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (sel) begin
        val_q <= wr_data_i;
      end
    end

    assign regs_o[g*BYTE_W +: BYTE_W] = val_q;
  end

  // Unmapped addresses read as zero
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr_i == ADDR_W'(i)) begin
        rd_data_o = regs_o[i*BYTE_W +: BYTE_W];
      end
    end
  end

endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_reg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned NUM_CTRL    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_sck,
  input  logic                       spi_cs_n,
  input  logic                       spi_sdi,
  output logic                       spi_sdo,
  output logic                       status_rd_o,
  output logic [ADDR_W-1:0]          status_addr_o,
  input  logic [BYTE_W-1:0]          status_data_i,
  output logic [NUM_CTRL*BYTE_W-1:0] ctrl_regs_o
);

  localparam int unsigned PIN_N    = 3;
  localparam int unsigned PIN_SCK  = 2;
  localparam int unsigned PIN_CS   = 1;
  localparam int unsigned PIN_SDI  = 0;
  localparam int unsigned STAT_BIT = ADDR_W - 1;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [PIN_N-1:0] pin_sync, pin_rise, pin_fall;

  spi_pin_sync #(
    .N       (PIN_N),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b010)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pins_i ({spi_sck, spi_cs_n, spi_sdi}),
    .sync_o (pin_sync),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  logic unused_edges;
  assign unused_edges = ^{pin_sync[PIN_SCK], pin_rise[PIN_SDI], pin_fall[PIN_SDI]};

  logic              load, shift, load_cmd, cmd_wr, commit;
  logic [ADDR_W-1:0] cur_addr;
  logic [BYTE_W-1:0] wr_data, ctrl_rd, rd_data;
  logic              is_status;

  spi_frame_rx #(
    .ADDR_W (ADDR_W)
  ) u_rx (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cs_active_i (~pin_sync[PIN_CS]),
    .cs_start_i  (pin_fall[PIN_CS]),
    .cs_end_i    (pin_rise[PIN_CS]),
    .sck_rise_i  (pin_rise[PIN_SCK]),
    .sck_fall_i  (pin_fall[PIN_SCK]),
    .sdi_i       (pin_sync[PIN_SDI]),
    .load_o      (load),
    .shift_o     (shift),
    .load_cmd_o  (load_cmd),
    .cmd_wr_o    (cmd_wr),
    .addr_o      (cur_addr),
    .commit_o    (commit),
    .wr_data_o   (wr_data)
  );

  spi_ctrl_regs #(
    .NUM_REGS (NUM_CTRL),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (commit),
    .wr_addr_i (cur_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (cur_addr),
    .rd_data_o (ctrl_rd),
    .regs_o    (ctrl_regs_o)
  );

  assign is_status = cur_addr[STAT_BIT];
  assign rd_data   = is_status ? status_data_i : ctrl_rd;

  spi_tx_shift u_tx (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_i  (load),
    .shift_i (shift),
    .data_i  (rd_data),
    .sdo_o   (spi_sdo)
  );

  // Strobe only for a read command; a write to status must not disturb it
  assign status_rd_o   = load & load_cmd & is_status & ~cmd_wr;
  assign status_addr_o = cur_addr;

endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk
  import spi_reg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned NUM_CTRL = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       spi_cs_n,
  input logic                       spi_sdo,
  input logic                       status_rd_o,
  input logic [ADDR_W-1:0]          status_addr_o,
  input logic [NUM_CTRL*BYTE_W-1:0] ctrl_regs_o
);

  // R1: quiet outputs while reset holds
  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      p_reset_quiet_r1: assert (spi_sdo == 1'b0 && ctrl_regs_o == '0 && !status_rd_o)
        else $error("reset state violated");
    end
  end

  // R3: strobe lasts a single clock
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd_o |=> !status_rd_o);

  // R3: strobe only names status addresses
  p_strobe_status_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd_o |-> status_addr_o[ADDR_W-1]);

  // R5: control registers change only after chip select has gone high
  p_commit_cs_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_regs_o) |-> $past(spi_cs_n));

  // R2: data out stays put while deselected
  p_sdo_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
      |=> $stable(spi_sdo));

endmodule

bind spi_reg_port spi_reg_port_chk #(
  .ADDR_W   (ADDR_W),
  .NUM_CTRL (NUM_CTRL)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .spi_cs_n      (spi_cs_n),
  .spi_sdo       (spi_sdo),
  .status_rd_o   (status_rd_o),
  .status_addr_o (status_addr_o),
  .ctrl_regs_o   (ctrl_regs_o)
);

// File: tb/spi_reg_port_tb.sv
module spi_reg_port_tb;

  localparam int ADDR_W   = 5;
  localparam int NUM_CTRL = 4;
  localparam int HALF     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic spi_sck = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_sdi = 1'b0;
  logic spi_sdo;
  logic status_rd;
  logic [ADDR_W-1:0] status_addr;
  logic [7:0] status_data;
  logic [NUM_CTRL*8-1:0] ctrl_regs;

  always #2 clk = ~clk;

  // status bank model: value derived from the address
  assign status_data = 8'h40 ^ {3'b000, status_addr};

  spi_reg_port #(.ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .spi_sck       (spi_sck),
    .spi_cs_n      (spi_cs_n),
    .spi_sdi       (spi_sdi),
    .spi_sdo       (spi_sdo),
    .status_rd_o   (status_rd),
    .status_addr_o (status_addr),
    .status_data_i (status_data),
    .ctrl_regs_o   (ctrl_regs)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int strobe_cnt = 0;
  logic [ADDR_W-1:0] strobe_addr = '0;

  logic [7:0] exp_q[$];
  logic [7:0] obs_q[$];
  string      tag_q[$];

  always @(negedge clk) begin
    if (status_rd === 1'b1) begin
      strobe_cnt++;
      strobe_addr = status_addr;
    end
  end

  // scoreboard monitor: compares each observed byte against its expectation
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] o, e;
        string t;
        o = obs_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (o !== e) begin
          n_fail++;
          $display("FAIL %s sdo byte: actual %02h expected %02h", t, o, e);
        end
      end
    end
  end

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] ctrl(input int i);
    return ctrl_regs[i*8 +: 8];
  endfunction

  task automatic cs_begin();
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  // driver: one byte, optionally pushing an expected response
  task automatic xfer(input logic [7:0] tx, input bit chk_en, input logic [7:0] exp,
                      input string tag);
    logic [7:0] got;
    if (chk_en) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    for (int i = 7; i >= 0; i--) begin
      spi_sdi = tx[i];
      repeat (HALF) @(negedge clk);
      got[i] = spi_sdo;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
    if (chk_en) obs_q.push_back(got);
  endtask

  task automatic xfer_bits(input logic [15:0] tx, input int nbits);
    for (int i = 15; i > 15 - nbits; i--) begin
      spi_sdi = tx[i];
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int s0;
    logic [31:0] snap;
    #1 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(spi_sdo, 0, "R1 sdo in reset");
    chk(ctrl_regs, 0, "R1 ctrl in reset");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(spi_sdo, 0, "R1 sdo after reset");
    chk(ctrl_regs, 0, "R1 ctrl after reset");
    chk(strobe_cnt, 0, "R1 no strobe after reset");

    // write ctrl1 = A5
    cs_begin();
    xfer(8'h81, 1, 8'h00, "R1 first byte");
    xfer(8'hA5, 1, 8'h00, "R8 old ctrl1 during write");
    chk(ctrl(1), 8'h00, "R5 ctrl1 held before cs rise");
    cs_end();
    chk(ctrl(1), 8'hA5, "R5 ctrl1 committed");

    // write ctrl3 = 7E with bits 6:5 set in command
    cs_begin();
    xfer(8'hE3, 1, 8'h00, "R8 load before commit");
    xfer(8'h7E, 1, 8'h00, "R8 old ctrl3");
    cs_end();
    chk(ctrl(3), 8'h7E, "R9 bits 6:5 ignored");

    // write ctrl0 = 3C
    cs_begin();
    xfer(8'h80, 1, 8'h00, "R8 carried old ctrl3");
    xfer(8'h3C, 1, 8'h00, "R8 old ctrl0");
    cs_end();
    chk(ctrl(0), 8'h3C, "R5 ctrl0 committed");

    // chained reads with select held low
    cs_begin();
    xfer(8'h01, 1, 8'h00, "R8 last load old ctrl0");
    xfer(8'h03, 1, 8'hA5, "R2 read ctrl1");
    xfer(8'h00, 1, 8'h7E, "R4 chained read ctrl3");
    xfer(8'h01, 1, 8'h3C, "R4 chained read ctrl0");
    cs_end();

    // status read
    s0 = strobe_cnt;
    cs_begin();
    xfer(8'h12, 1, 8'hA5, "R4 carried ctrl1");
    xfer(8'h00, 1, 8'h52, "R3 status data");
    cs_end();
    chk(strobe_cnt, s0 + 1, "R3 one strobe");
    chk(strobe_addr, 5'h12, "R3 strobe address");

    // 15-bit write is dropped
    snap = ctrl_regs;
    cs_begin();
    xfer_bits(16'h8255, 15);
    cs_end();
    chk(ctrl(2), 8'h00, "R6 15-bit write dropped");

    // 24-bit write is dropped
    cs_begin();
    xfer(8'h82, 0, 8'h00, "");
    xfer(8'h55, 0, 8'h00, "");
    xfer(8'h00, 0, 8'h00, "");
    cs_end();
    chk(ctrl_regs, snap, "R6 24-bit write dropped");

    // writes to status and unmapped addresses
    s0 = strobe_cnt;
    cs_begin();
    xfer(8'h95, 0, 8'h00, "");
    xfer(8'hFF, 0, 8'h00, "");
    cs_end();
    chk(ctrl_regs, snap, "R7 status write ignored");
    chk(strobe_cnt, s0, "R7 no strobe on status write");
    cs_begin();
    xfer(8'h8A, 0, 8'h00, "");
    xfer(8'hFF, 0, 8'h00, "");
    cs_end();
    chk(ctrl_regs, snap, "R7 unmapped write ignored");

    cs_begin();
    xfer(8'h02, 1, 8'h00, "R7 unmapped reads zero");
    xfer(8'h00, 1, 8'h00, "R6 ctrl2 still zero");
    cs_end();

    // all-ones write then read back
    cs_begin();
    xfer(8'h82, 0, 8'h00, "");
    xfer(8'hFF, 0, 8'h00, "");
    cs_end();
    chk(ctrl(2), 8'hFF, "R5 ctrl2 all ones");
    cs_begin();
    xfer(8'h02, 1, 8'h00, "R8 old ctrl2 loaded");
    xfer(8'h00, 1, 8'hFF, "R2 read ctrl2");
    cs_end();

    repeat (20) @(negedge clk);
    summary();
    $finish;
  end

endmodule